// File: doc/BRIEF.md
# Endianness Conversion Bridge

This block sits on the path from a host processor into a slave subsystem. It can exchange the two 16-bit halves of a 32-bit value, exchange the two bytes inside each 16-bit half, or do both. One control register inside the bridge holds two 2-bit selectors: one for the half exchange and one for the byte exchange. Each selector enables its exchange for internal-memory accesses, for shared-peripheral accesses, for both or for neither. The target region of each access is decoded from its address. Addresses outside both regions are never converted.

The host presents requests on a valid/ready channel. A request is accepted in a cycle where `h_valid` and `h_ready` are both high. While `h_ready` is low, the host must hold the request stable. For forwarded accesses `h_ready` follows the slave's `s_ready`. A request to the control register is always accepted at once and is never forwarded to the slave. Write data is converted on its way to the slave in the same cycle. For a read, the slave presents `s_rdata` in the cycle of acceptance. The converted value reaches the host one cycle later, flagged by `h_rvalid`. The response channel has no back-pressure. For a 16-bit access the data occupies bits [15:0]. Bits [31:16] of converted data are zero.

Top module: `endian_bridge`

## Requirements
- R1: After reset both selectors are 00, `h_rvalid` is low, and data passes through unchanged.
- R2: A 32-bit slave value 0x12345678 reads as 0x12345678 with no exchange, 0x34127856 with byte exchange only, 0x56781234 with half exchange only, and 0x78563412 with both.
- R3: On a 16-bit access, a value 0x1234 reads as 0x3412 whenever byte exchange applies and as 0x1234 otherwise. Half exchange has no effect, and bits [31:16] of the result are zero.
- R4: Within each selector, bit 0 enables the exchange for internal memory and bit 1 enables it for shared peripherals. Internal memory is any address with bits [31:24] = 0xE0, and shared peripherals are any address with bits [31:24] = 0xE1. Any other address is never converted.
- R5: Write data sent to the slave on `s_wdata` is converted with the same rules as read data, in the same cycle the request is presented. A write followed by a read under unchanged settings therefore returns the original value.
- R6: A read is answered exactly one cycle after its acceptance by `h_rvalid` high together with its data. A cycle with no accepted read produces no response in the next cycle, and writes never produce a response.
- R7: The control register is at address 0xFFFEC900. Write data bits [1:0] load the half-exchange selector and bits [3:2] load the byte-exchange selector. A read returns the two selectors in the same positions with all other bits zero. Such requests keep `s_valid` low and `h_ready` high.
- R8: A new setting applies to every access accepted in any cycle after the control write is accepted, including the very next cycle. A response already in flight keeps the conversion chosen when its read was accepted.
- R9: While a forwarded request waits with `s_ready` low, `h_ready` is low and no response is produced. The request completes normally once `s_ready` rises.
- R10: With both selectors at 00, data passes through unchanged for every region and both access sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Bridge can accept the request |
| h_write | input | 1 | 1 = write, 0 = read |
| h_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| h_addr | input | 32 | Request address |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read response valid |
| h_rdata | output | 32 | Converted read data |
| s_valid | output | 1 | Forwarded request valid |
| s_ready | input | 1 | Slave accepts the request |
| s_write | output | 1 | Forwarded direction |
| s_wide | output | 1 | Forwarded access size |
| s_addr | output | 32 | Forwarded address |
| s_wdata | output | 32 | Converted write data |
| s_rdata | input | 32 | Slave read data, valid in the acceptance cycle |

## Verification
Two events can coincide in one cycle: a control-register write being accepted, and the registered response of the read accepted just before it appearing on `h_rdata`. The bench provokes this case directly. It issues a read, and in the very next cycle it writes new selectors while the response of that read is on the port. It then checks that the response carries the old conversion. A read issued in the following cycle must already carry the new conversion. Random stimulus mixes control writes between accesses of all sizes and regions, and adds random back-pressure pauses. The results are compared with a conversion model in the bench.

// File: rtl/endian_pkg.sv
package endian_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = 16;
  localparam int NUM_HALF = DATA_W / HALF_W;
  localparam int SEL_W    = 2;

  typedef struct packed {
    logic per;
    logic mem;
  } swap_sel_t;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_MEM  = 2'd1,
    RGN_PER  = 2'd2,
    RGN_CTRL = 2'd3
  } region_e;

  function automatic logic sel_applies(swap_sel_t sel, region_e rgn);
    return (rgn == RGN_MEM && sel.mem) || (rgn == RGN_PER && sel.per);
  endfunction
endpackage

// File: rtl/endian_ctrl_reg.sv
module endian_ctrl_reg
  import endian_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output swap_sel_t  half_sel,
  output swap_sel_t  byte_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_sel <= '0;
      byte_sel <= '0;
    end else if (wr_en) begin
      half_sel <= swap_sel_t'(wr_data[1:0]);
      byte_sel <= swap_sel_t'(wr_data[3:2]);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(half_sel) && $stable(byte_sel)));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({byte_sel, half_sel} == $past(wr_data)));
endmodule

// File: rtl/endian_region_decode.sv
module endian_region_decode
  import endian_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'hFFFE_C900,
  parameter logic [31:0] MEM_BASE  = 32'hE000_0000,
  parameter logic [31:0] PER_BASE  = 32'hE100_0000,
  parameter logic [31:0] RGN_MASK  = 32'hFF00_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn
);
  logic [ADDR_W-1:0] mask_a;
  assign mask_a = addr & RGN_MASK[ADDR_W-1:0];

  always_comb begin
    if (addr == CTRL_ADDR[ADDR_W-1:0])       rgn = RGN_CTRL;
    else if (mask_a == MEM_BASE[ADDR_W-1:0]) rgn = RGN_MEM;
    else if (mask_a == PER_BASE[ADDR_W-1:0]) rgn = RGN_PER;
    else                                     rgn = RGN_NONE;
  end
endmodule

// File: rtl/endian_swap_unit.sv
module endian_swap_unit
  import endian_pkg::*;
(
  input  logic [DATA_W-1:0] din,
  input  logic              wide,
  input  logic              do_half,
  input  logic              do_byte,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] half_x;
  logic [DATA_W-1:0] byte_x;

  assign half_x = (wide && do_half) ? {din[HALF_W-1:0], din[DATA_W-1:HALF_W]} : din;

  for (genvar g = 0; g < NUM_HALF; g++) begin : g_lane
    assign byte_x[g*HALF_W +: HALF_W] = do_byte
      ? {half_x[g*HALF_W +: 8], half_x[g*HALF_W+8 +: 8]}
      : half_x[g*HALF_W +: HALF_W];
  end

  assign dout = wide ? byte_x : {{(DATA_W-HALF_W){1'b0}}, byte_x[HALF_W-1:0]};
endmodule

// File: rtl/endian_bridge.sv
module endian_bridge
  import endian_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] CTRL_ADDR = 32'hFFFE_C900,
  parameter logic [31:0] MEM_BASE  = 32'hE000_0000,
  parameter logic [31:0] PER_BASE  = 32'hE100_0000,
  parameter logic [31:0] RGN_MASK  = 32'hFF00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_valid,
  output logic              h_ready,
  input  logic              h_write,
  input  logic              h_wide,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  output logic              s_valid,
  input  logic              s_ready,
  output logic              s_write,
  output logic              s_wide,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_wdata,
  input  logic [DATA_W-1:0] s_rdata
);
  region_e   rgn;
  swap_sel_t half_sel, byte_sel;
  logic      ctrl_hit, half_en, byte_en, acc_rd, ctrl_wr;
  logic [DATA_W-1:0] rd_conv;
  logic      rsp_wide;

  endian_region_decode #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MEM_BASE(MEM_BASE),
    .PER_BASE(PER_BASE), .RGN_MASK(RGN_MASK)
  ) u_dec (.addr(h_addr), .rgn(rgn));

  assign ctrl_hit = (rgn == RGN_CTRL);
  assign ctrl_wr  = h_valid && ctrl_hit && h_write;

  endian_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_data(h_wdata[3:0]),
    .half_sel(half_sel), .byte_sel(byte_sel)
  );

  assign half_en = sel_applies(half_sel, rgn);
  assign byte_en = sel_applies(byte_sel, rgn);

  endian_swap_unit u_wr_swap (
    .din(h_wdata), .wide(h_wide), .do_half(half_en), .do_byte(byte_en), .dout(s_wdata)
  );
  endian_swap_unit u_rd_swap (
    .din(s_rdata), .wide(h_wide), .do_half(half_en), .do_byte(byte_en), .dout(rd_conv)
  );

  assign s_valid = h_valid && !ctrl_hit;
  assign s_write = h_write;
  assign s_wide  = h_wide;
  assign s_addr  = h_addr;
  assign h_ready = ctrl_hit ? 1'b1 : s_ready;
  assign acc_rd  = h_valid && h_ready && !h_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_rvalid <= 1'b0;
      h_rdata  <= '0;
      rsp_wide <= 1'b0;
    end else begin
      h_rvalid <= acc_rd;
      if (acc_rd) begin
        h_rdata  <= ctrl_hit ? {{(DATA_W-4){1'b0}}, byte_sel, half_sel} : rd_conv;
        rsp_wide <= h_wide;
      end
    end
  end

  assert_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && !h_write) |=> h_rvalid);

  assert_no_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && h_ready && !h_write) |=> !h_rvalid);

  assert_ctrl_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && ctrl_hit) |-> (!s_valid && h_ready));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |-> !h_ready);

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rvalid && !rsp_wide) |-> (h_rdata[DATA_W-1:HALF_W] == '0));

  assert_unmapped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && rgn == RGN_NONE && h_wide) |-> (s_wdata == h_wdata));
endmodule

// File: tb/sim_endian_bridge.sv
`timescale 1ns/1ps
module sim_endian_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0, h_write = 1'b0, h_wide = 1'b1, s_ready = 1'b1;
  logic [31:0] h_addr = '0, h_wdata = '0, s_rdata = '0;
  logic        h_ready, h_rvalid, s_valid, s_write, s_wide;
  logic [31:0] h_rdata, s_addr, s_wdata;

  int tests = 0, fails = 0;
  logic [1:0] m_half = 2'b00, m_byte = 2'b00;   // bench-side copy of the selectors

  localparam logic [31:0] CTRL = 32'hFFFE_C900;

  always #2.5 clk = ~clk;   // 200 MHz

  endian_bridge u0 (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_wide(h_wide), .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .s_valid(s_valid), .s_ready(s_ready), .s_write(s_write),
    .s_wide(s_wide), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // region code: 0 none, 1 memory, 2 peripherals
  function automatic logic [31:0] addr_of(input int rg, input logic [23:0] off);
    case (rg)
      1:       return {8'hE0, off};
      2:       return {8'hE1, off};
      default: return {8'h20, off};
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] d, input bit wide, input int rg,
                                        input logic [1:0] hs, input logic [1:0] bs);
    bit doh, dob;
    logic [31:0] t;
    doh = (rg == 1 && hs[0]) || (rg == 2 && hs[1]);
    dob = (rg == 1 && bs[0]) || (rg == 2 && bs[1]);
    if (!wide) return {16'h0, dob ? {d[7:0], d[15:8]} : d[15:0]};
    t = doh ? {d[15:0], d[31:16]} : d;
    return dob ? {t[23:16], t[31:24], t[7:0], t[15:8]} : t;
  endfunction

  task automatic ctrl_write(input logic [1:0] hs, input logic [1:0] bs);
    @(negedge clk);
    h_valid = 1; h_write = 1; h_wide = 1; h_addr = CTRL; h_wdata = {28'h0, bs, hs};
    #1 check(!s_valid && h_ready, "R7 ctrl not forwarded", {30'h0, s_valid, h_ready}, 32'h1);
    @(negedge clk);
    h_valid = 0;
    m_half = hs; m_byte = bs;
  endtask

  task automatic do_read(input logic [31:0] a, input bit wide, input logic [31:0] sd,
                         input logic [31:0] exp, input string req);
    @(negedge clk);
    h_valid = 1; h_write = 0; h_wide = wide; h_addr = a; s_rdata = sd;
    @(negedge clk);
    h_valid = 0;
    check(h_rvalid && h_rdata == exp, req, h_rdata, exp);
  endtask

  task automatic do_write(input logic [31:0] a, input bit wide, input logic [31:0] d,
                          input logic [31:0] exp, input string req);
    @(negedge clk);
    h_valid = 1; h_write = 1; h_wide = wide; h_addr = a; h_wdata = d;
    #1 check(s_valid && s_write && s_wdata == exp, req, s_wdata, exp);
    @(negedge clk);
    h_valid = 0;
    check(!h_rvalid, "R6 no response to write", {31'h0, h_rvalid}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!h_rvalid, "R1 no response after reset", {31'h0, h_rvalid}, 32'h0);
    do_read(CTRL, 1, 32'hDEAD_BEEF, 32'h0, "R1 selectors clear after reset");
    do_read(addr_of(1, 24'h10), 1, 32'h1234_5678, 32'h1234_5678, "R1 R10 passthrough wide");
    do_read(addr_of(2, 24'h10), 0, 32'hABCD_1234, 32'h0000_1234, "R10 passthrough narrow");

    // R2 table on memory
    ctrl_write(2'b00, 2'b01);
    do_read(addr_of(1, 24'h4), 1, 32'h1234_5678, 32'h3412_7856, "R2 byte only");
    ctrl_write(2'b01, 2'b00);
    do_read(addr_of(1, 24'h4), 1, 32'h1234_5678, 32'h5678_1234, "R2 half only");
    ctrl_write(2'b01, 2'b01);
    do_read(addr_of(1, 24'h4), 1, 32'h1234_5678, 32'h7856_3412, "R2 both");
    do_read(CTRL, 0, 32'h0, 32'h0000_0005, "R7 ctrl readback");

    // R3 narrow
    do_read(addr_of(1, 24'h8), 0, 32'hFFFF_1234, 32'h0000_3412, "R3 narrow byte");
    ctrl_write(2'b11, 2'b00);
    do_read(addr_of(1, 24'h8), 0, 32'h0000_1234, 32'h0000_1234, "R3 narrow half ignored");

    // R4 region selection
    ctrl_write(2'b01, 2'b10);
    do_read(addr_of(2, 24'h0), 1, 32'h1234_5678, 32'h3412_7856, "R4 periph byte only");
    do_read(addr_of(1, 24'h0), 1, 32'h1234_5678, 32'h5678_1234, "R4 memory half only");
    ctrl_write(2'b11, 2'b11);
    do_read(addr_of(0, 24'h0), 1, 32'h1234_5678, 32'h1234_5678, "R4 unmapped untouched");
    do_write(addr_of(0, 24'h0), 1, 32'hCAFE_F00D, 32'hCAFE_F00D, "R4 unmapped write untouched");

    // R5 write conversion and round trip
    do_write(addr_of(1, 24'h0), 1, 32'h1234_5678, 32'h7856_3412, "R5 write converted");
    do_read(addr_of(1, 24'h0), 1, 32'h7856_3412, 32'h1234_5678, "R5 round trip");
    do_write(addr_of(2, 24'h2), 0, 32'h5555_A1B2, 32'h0000_B2A1, "R5 narrow write");

    // R8: response in flight while selectors change, then immediate use
    ctrl_write(2'b00, 2'b00);
    @(negedge clk);
    h_valid = 1; h_write = 0; h_wide = 1; h_addr = addr_of(1, 24'h20); s_rdata = 32'h1234_5678;
    @(negedge clk);
    h_write = 1; h_addr = CTRL; h_wdata = 32'h5;
    #1 check(h_rvalid && h_rdata == 32'h1234_5678, "R8 in-flight keeps old setting", h_rdata, 32'h1234_5678);
    @(negedge clk);
    m_half = 2'b01; m_byte = 2'b01;
    h_write = 0; h_addr = addr_of(1, 24'h24); s_rdata = 32'h1234_5678;
    @(negedge clk);
    h_valid = 0;
    check(h_rvalid && h_rdata == 32'h7856_3412, "R8 next-cycle access uses new setting", h_rdata, 32'h7856_3412);

    // R9 back-pressure
    @(negedge clk);
    s_ready = 0;
    h_valid = 1; h_write = 0; h_wide = 1; h_addr = addr_of(2, 24'h0); s_rdata = 32'h1122_3344;
    #1 check(!h_ready, "R9 ready follows slave", {31'h0, h_ready}, 32'h0);
    @(negedge clk);
    check(!h_rvalid, "R9 no response while stalled", {31'h0, h_rvalid}, 32'h0);
    s_ready = 1;
    @(negedge clk);
    h_valid = 0;
    check(h_rvalid && h_rdata == 32'h1122_3344, "R9 completes after stall", h_rdata, 32'h1122_3344);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int rg;
      bit wide;
      logic [31:0] d, a;
      rg = int'($urandom_range(0, 2));
      wide = 1'($urandom_range(0, 1));
      d = $urandom;
      a = addr_of(rg, 24'($urandom));
      case ($urandom_range(0, 4))
        0: ctrl_write(2'($urandom), 2'($urandom));
        1: do_write(a, wide, d, model(d, wide, rg, m_half, m_byte), "R5 random write");
        2: begin
          @(negedge clk);
          s_ready = 0;
          h_valid = 1; h_write = 0; h_wide = wide; h_addr = a; s_rdata = d;
          @(negedge clk);
          check(!h_rvalid, "R9 random stall", {31'h0, h_rvalid}, 32'h0);
          s_ready = 1;
          @(negedge clk);
          h_valid = 0;
          check(h_rvalid && h_rdata == model(d, wide, rg, m_half, m_byte), "R2 R3 R4 random stalled read",
                h_rdata, model(d, wide, rg, m_half, m_byte));
        end
        default: do_read(a, wide, d, model(d, wide, rg, m_half, m_byte), "R2 R3 R4 random read");
      endcase
    end

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule